// File: doc/BRIEF.md
# Framed Message Packet Decoder

This block sits behind a serial byte receiver and turns a sparse stream of bytes into framed messages. A frame opens with a fixed start code, carries a header with a message kind, a target address and a payload length, then the payload, and closes with a one-byte checksum. The decoder parses the header through a shift register and accumulates the checksum as bytes arrive. It stages the payload in a local buffer.

When the closing checksum byte arrives, the decoder compares it with its own sum and checks that the message kind is known. Only a frame that passes both tests is committed. Its payload is then played out as one write per clock to either the register-bank port or the memory port, at consecutive addresses from the header address. Every completed frame, good or bad, leaves its verdict in a three-bit status register that the host can read at any time, along with a one-cycle pass or fail pulse. A frame that stalls mid-way is abandoned after a programmable number of idle cycles.

Top module: `frame_msg_decoder`

## Requirements
- R1: After reset the status register reads 000, both write strobes are low and both verdict pulses are low.
- R2: A frame is the byte 0xA5, a kind byte, the address high byte, the address low byte, a length byte, the payload bytes, and a checksum byte. The checksum equals the modulo-256 sum of every byte after 0xA5 and before the checksum. When the checksum matches and the kind is known, msg_ok is high for exactly the cycle after the checksum byte is taken, and status becomes 001.
- R3: The payload of a committed frame is written on consecutive cycles. The first write is in the cycle after the checksum byte is taken. Write i carries address base+i, taken modulo 2^16, and payload byte i.
- R4: Kind 0x01 writes through reg_we. A payload byte equal to 0xA5 is treated as plain data.
- R5: Kind 0x02 writes through mem_we. reg_we and mem_we are never high together.
- R6: When the checksum does not match, msg_err is high for one cycle, status bit 1 is set, and no write occurs.
- R7: A kind other than 0x01 or 0x02 sets status bit 2, raises msg_err and produces no write. If the checksum is also wrong, status reads 110.
- R8: A length byte of 0 denotes a 256-byte payload.
- R9: While the decoder waits for a frame, every byte other than 0xA5 is ignored.
- R10: Inside a frame, if idle_limit is non-zero and idle_limit consecutive clock edges pass with no byte, the decoder drops the frame and waits for 0xA5 again. A byte that arrives on the idle_limit-th edge keeps the frame alive.
- R11: When idle_limit is 0, a frame may pause for any length of time.
- R12: Bytes that arrive while a committed payload is still being written out are ignored.
- R13: The status register keeps its value until the next frame reaches its checksum byte. An abandoned frame changes neither the status register nor the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| idle_limit | input | TMO_W | Idle cycles before a partial frame is dropped (0 = never) |
| reg_we | output | 1 | Register-bank write strobe |
| mem_we | output | 1 | Memory write strobe |
| wr_addr | output | 8*ADDR_BYTES | Write address for either port |
| wr_data | output | 8 | Write data for either port |
| msg_ok | output | 1 | One-cycle pulse: frame accepted |
| msg_err | output | 1 | One-cycle pulse: frame rejected |
| status | output | 3 | Last verdict: bit0 good, bit1 checksum bad, bit2 kind unknown |

## Verification
The bench sends a payload that contains the start code. A parser that resynchronises on every 0xA5 would break that frame and get the checksum wrong. It sends frames with a wrong sum, an unknown kind, or both, and any write leaking from those frames shows up as an unexpected strobe. A frame with a zero length byte must produce 256 writes, and it also has bytes injected during its write-out. A decoder that accepts those bytes would swallow the start of the next frame. The idle timeout is tested at its exact boundary, with a pause that must be survived and a longer one that must abort the frame without disturbing the status. A base address near the top of the range checks that the address wraps.

// File: rtl/pktdec_pkg.sv
package pktdec_pkg;

   typedef enum logic [2:0] {
      PS_HUNT,
      PS_KIND,
      PS_ADDR,
      PS_LEN,
      PS_BODY,
      PS_SUM,
      PS_DRAIN
   } parse_st_e;

   typedef enum logic [1:0] {
      DST_NONE,
      DST_REG,
      DST_MEM
   } dest_e;

   typedef struct packed {
      logic kind_bad;
      logic sum_bad;
      logic good;
   } frame_stat_t;

   localparam int unsigned BODY_DEPTH = 256;
   localparam int unsigned BODY_IW    = 8;
   localparam int unsigned COUNT_W    = 9;

endpackage

// File: rtl/pktdec_parser.sv
module pktdec_parser
   import pktdec_pkg::*;
#(
   parameter logic [7:0] START_CODE       = 8'hA5,
   parameter logic [7:0] KIND_REG         = 8'h01,
   parameter logic [7:0] KIND_MEM         = 8'h02,
   parameter int         ADDR_BYTES       = 2,
   parameter int         TMO_W            = 16,
   parameter bit         USE_IDLE_TIMEOUT = 1'b1,
   localparam int        ADDR_W           = 8 * ADDR_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [7:0]           in_byte,
   input  logic [TMO_W-1:0]     idle_limit,
   input  logic                 drain_done,
   output logic                 buf_we,
   output logic [BODY_IW-1:0]   buf_idx,
   output logic [7:0]           buf_wdata,
   output logic                 commit_go,
   output dest_e                hdr_dest,
   output logic [ADDR_W-1:0]    hdr_base,
   output logic [COUNT_W-1:0]   hdr_count,
   output logic                 stat_we,
   output frame_stat_t          stat_next
);

   localparam int HSW = 8 * (ADDR_BYTES + 1);
   localparam int HDW = HSW + 8;
   localparam int ACW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

   parse_st_e            state;
   logic [HSW-1:0]       hdr_sr;
   logic [HDW-1:0]       hdr_full;
   logic [ACW-1:0]       addr_cnt;
   logic [7:0]           kind_q;
   logic [ADDR_W-1:0]    base_q;
   logic [COUNT_W-1:0]   count_q;
   logic [COUNT_W-1:0]   remain;
   logic [BODY_IW-1:0]   idx;
   logic [7:0]           sum;
   logic                 tmo_fire;
   logic                 in_frame;
   logic                 kind_ok;
   logic                 sum_match;

   assign hdr_full  = {hdr_sr, in_byte};
   assign in_frame  = (state inside {PS_KIND, PS_ADDR, PS_LEN, PS_BODY, PS_SUM});
   assign kind_ok   = (kind_q == KIND_REG) || (kind_q == KIND_MEM);
   assign sum_match = (sum == in_byte);

   always_comb begin
      hdr_dest = DST_NONE;
      if (kind_q == KIND_REG)      hdr_dest = DST_REG;
      else if (kind_q == KIND_MEM) hdr_dest = DST_MEM;
   end

   assign hdr_base  = base_q;
   assign hdr_count = count_q;

   assign buf_we    = in_valid && (state == PS_BODY);
   assign buf_idx   = idx;
   assign buf_wdata = in_byte;

   assign stat_we            = in_valid && (state == PS_SUM);
   assign commit_go          = stat_we && sum_match && kind_ok;
   assign stat_next.kind_bad = !kind_ok;
   assign stat_next.sum_bad  = !sum_match;
   assign stat_next.good     = sum_match && kind_ok;

   generate
      if (USE_IDLE_TIMEOUT) begin : g_tmo
         logic [TMO_W-1:0] idle_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   idle_cnt <= '0;
            else if (!in_frame || in_valid) idle_cnt <= '0;
            else                          idle_cnt <= idle_cnt + 1'b1;
         end
         assign tmo_fire = in_frame && !in_valid && (idle_limit != '0) &&
                           (idle_cnt == idle_limit - 1'b1);
      end else begin : g_no_tmo
         assign tmo_fire = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PS_HUNT;
         hdr_sr   <= '0;
         addr_cnt <= '0;
         kind_q   <= '0;
         base_q   <= '0;
         count_q  <= '0;
         remain   <= '0;
         idx      <= '0;
         sum      <= '0;
      end else if (state == PS_DRAIN) begin
         if (drain_done) state <= PS_HUNT;
      end else if (tmo_fire) begin
         state <= PS_HUNT;
      end else if (in_valid) begin
         unique case (state)
            PS_HUNT: begin
               if (in_byte == START_CODE) state <= PS_KIND;
            end
            PS_KIND: begin
               hdr_sr   <= {hdr_sr[HSW-9:0], in_byte};
               sum      <= in_byte;
               addr_cnt <= '0;
               state    <= PS_ADDR;
            end
            PS_ADDR: begin
               hdr_sr <= {hdr_sr[HSW-9:0], in_byte};
               sum    <= sum + in_byte;
               if (addr_cnt == ACW'(ADDR_BYTES - 1)) state <= PS_LEN;
               else addr_cnt <= addr_cnt + 1'b1;
            end
            PS_LEN: begin
               sum     <= sum + in_byte;
               kind_q  <= hdr_full[HDW-1 -: 8];
               base_q  <= hdr_full[8 +: ADDR_W];
               count_q <= (in_byte == 8'd0) ? COUNT_W'(BODY_DEPTH) : {1'b0, in_byte};
               remain  <= (in_byte == 8'd0) ? COUNT_W'(BODY_DEPTH) : {1'b0, in_byte};
               idx     <= '0;
               state   <= PS_BODY;
            end
            PS_BODY: begin
               sum    <= sum + in_byte;
               idx    <= idx + 1'b1;
               remain <= remain - 1'b1;
               if (remain == COUNT_W'(1)) state <= PS_SUM;
            end
            PS_SUM: begin
               state <= commit_go ? PS_DRAIN : PS_HUNT;
            end
            default: state <= PS_HUNT;
         endcase
      end
   end

endmodule

// File: rtl/pktdec_body_buf.sv
module pktdec_body_buf #(
   parameter int DEPTH = 256,
   parameter int DW    = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_idx] <= wr_data;
   end

   assign rd_data = store[rd_idx];

endmodule

// File: rtl/pktdec_commit.sv
module pktdec_commit
   import pktdec_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  dest_e               dest_in,
   input  logic [ADDR_W-1:0]   base_in,
   input  logic [COUNT_W-1:0]  count_in,
   output logic [BODY_IW-1:0]  rd_idx,
   input  logic [7:0]          rd_data,
   output logic                reg_we,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [7:0]          wr_data,
   output logic                done
);

   logic               active;
   dest_e              dest_q;
   logic [ADDR_W-1:0]  base_q;
   logic [COUNT_W-1:0] last_q;
   logic [COUNT_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         dest_q <= DST_NONE;
         base_q <= '0;
         last_q <= '0;
         idx_q  <= '0;
      end else if (go) begin
         active <= 1'b1;
         dest_q <= dest_in;
         base_q <= base_in;
         last_q <= count_in - 1'b1;
         idx_q  <= '0;
      end else if (active) begin
         if (idx_q == last_q) active <= 1'b0;
         else                 idx_q  <= idx_q + 1'b1;
      end
   end

   assign done    = active && (idx_q == last_q);
   assign rd_idx  = idx_q[BODY_IW-1:0];
   assign reg_we  = active && (dest_q == DST_REG);
   assign mem_we  = active && (dest_q == DST_MEM);
   assign wr_addr = base_q + ADDR_W'(idx_q);
   assign wr_data = rd_data;

endmodule

// File: rtl/frame_msg_decoder.sv
module frame_msg_decoder
   import pktdec_pkg::*;
#(
   parameter logic [7:0] START_CODE       = 8'hA5,
   parameter logic [7:0] KIND_REG         = 8'h01,
   parameter logic [7:0] KIND_MEM         = 8'h02,
   parameter int         ADDR_BYTES       = 2,
   parameter int         TMO_W            = 16,
   parameter bit         USE_IDLE_TIMEOUT = 1'b1,
   localparam int        ADDR_W           = 8 * ADDR_BYTES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [7:0]         in_byte,
   input  logic [TMO_W-1:0]   idle_limit,
   output logic               reg_we,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [7:0]         wr_data,
   output logic               msg_ok,
   output logic               msg_err,
   output logic [2:0]         status
);

   generate
      if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_addr
         $error("frame_msg_decoder: ADDR_BYTES must lie in 1..4");
      end
      if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo
         $error("frame_msg_decoder: TMO_W must lie in 1..32");
      end
      if (KIND_REG == KIND_MEM) begin : g_bad_kind
         $error("frame_msg_decoder: the two kind codes must differ");
      end
   endgenerate

   logic                buf_we;
   logic [BODY_IW-1:0]  buf_idx;
   logic [7:0]          buf_wdata;
   logic [BODY_IW-1:0]  rd_idx;
   logic [7:0]          rd_data;
   logic                commit_go;
   dest_e               hdr_dest;
   logic [ADDR_W-1:0]   hdr_base;
   logic [COUNT_W-1:0]  hdr_count;
   logic                stat_we;
   frame_stat_t         stat_next;
   logic                drain_done;
   frame_stat_t         stat_q;

   pktdec_parser #(
      .START_CODE       (START_CODE),
      .KIND_REG         (KIND_REG),
      .KIND_MEM         (KIND_MEM),
      .ADDR_BYTES       (ADDR_BYTES),
      .TMO_W            (TMO_W),
      .USE_IDLE_TIMEOUT (USE_IDLE_TIMEOUT)
   ) u_parser (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_byte    (in_byte),
      .idle_limit (idle_limit),
      .drain_done (drain_done),
      .buf_we     (buf_we),
      .buf_idx    (buf_idx),
      .buf_wdata  (buf_wdata),
      .commit_go  (commit_go),
      .hdr_dest   (hdr_dest),
      .hdr_base   (hdr_base),
      .hdr_count  (hdr_count),
      .stat_we    (stat_we),
      .stat_next  (stat_next)
   );

   pktdec_body_buf #(
      .DEPTH (BODY_DEPTH),
      .DW    (8)
   ) u_buf (
      .clk     (clk),
      .wr_en   (buf_we),
      .wr_idx  (buf_idx),
      .wr_data (buf_wdata),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   pktdec_commit #(
      .ADDR_W (ADDR_W)
   ) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (commit_go),
      .dest_in  (hdr_dest),
      .base_in  (hdr_base),
      .count_in (hdr_count),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .reg_we   (reg_we),
      .mem_we   (mem_we),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .done     (drain_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= '0;
         msg_ok  <= 1'b0;
         msg_err <= 1'b0;
      end else begin
         msg_ok  <= stat_we && stat_next.good;
         msg_err <= stat_we && !stat_next.good;
         if (stat_we) stat_q <= stat_next;
      end
   end

   assign status = stat_q;

endmodule

// File: rtl/frame_msg_decoder_chk.sv
module frame_msg_decoder_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic              mem_we,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              msg_ok,
   input logic              msg_err,
   input logic [2:0]        status
);

   logic any_we;
   assign any_we = reg_we || mem_we;

   assert_single_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && mem_we));

   assert_dest_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && $past(any_we)) |-> $past(reg_we));

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (any_we && $past(any_we)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

   assert_write_after_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_we) |-> msg_ok);

   assert_err_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      msg_err |-> !any_we);

   assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(msg_ok && msg_err));

   assert_ok_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
      msg_ok |-> (status == 3'b001));

   assert_err_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      msg_err |-> (status[0] == 1'b0 && status[2:1] != 2'b00));

   assert_status_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_ok && !msg_err) |-> $stable(status));

endmodule

bind frame_msg_decoder frame_msg_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_we  (reg_we),
   .mem_we  (mem_we),
   .wr_addr (wr_addr),
   .msg_ok  (msg_ok),
   .msg_err (msg_err),
   .status  (status)
);

// File: tb/frame_msg_decoder_tb.sv
module frame_msg_decoder_tb;

   localparam logic [7:0] SC   = 8'hA5;
   localparam logic [7:0] KREG = 8'h01;
   localparam logic [7:0] KMEM = 8'h02;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [7:0]  in_byte;
   logic [15:0] idle_limit;
   logic        reg_we, mem_we;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;
   logic        msg_ok, msg_err;
   logic [2:0]  status;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   bit         q_isreg [$];
   logic [15:0] q_addr [$];
   logic [7:0]  q_data [$];

   always #5 clk = ~clk;

   frame_msg_decoder u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_byte    (in_byte),
      .idle_limit (idle_limit),
      .reg_we     (reg_we),
      .mem_we     (mem_we),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .msg_ok     (msg_ok),
      .msg_err    (msg_err),
      .status     (status)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   // every clock: each strobe must match the head of the expected write queue
   always @(negedge clk) begin
      if (rst_n === 1'b1 && (reg_we || mem_we)) begin
         if (q_addr.size() == 0) begin
            chk("R6", "unexpected write strobe", {reg_we, mem_we}, 0);
         end else begin
            chk("R5", "write port kind", {reg_we, mem_we},
                q_isreg[0] ? 2'b10 : 2'b01);
            chk("R3", "write address", wr_addr, q_addr[0]);
            chk("R3", "write data", wr_data, q_data[0]);
            void'(q_isreg.pop_front());
            void'(q_addr.pop_front());
            void'(q_data.pop_front());
         end
      end
   end

   task automatic send_byte(input logic [7:0] b, input int gap);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'h00;
      repeat (gap) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] kind, input logic [15:0] addr,
                             input int len, input logic [7:0] seed,
                             input bit bad_sum, input int pause_at,
                             input int pause, input bit inject,
                             input string req);
      logic [7:0] fr [$];
      logic [7:0] s;
      logic [7:0] d;
      bit         kind_ok;
      bit         good;
      logic [2:0] exp_st;
      kind_ok = (kind == KREG) || (kind == KMEM);
      good    = kind_ok && !bad_sum;
      exp_st  = {!kind_ok, bad_sum, good};
      fr.push_back(SC);
      fr.push_back(kind);
      fr.push_back(addr[15:8]);
      fr.push_back(addr[7:0]);
      fr.push_back(8'(len));
      for (int i = 0; i < len; i++) begin
         d = (i == 1) ? SC : 8'(seed + 8'(i * 29));
         fr.push_back(d);
         if (good) begin
            q_isreg.push_back(kind == KREG);
            q_addr.push_back(16'(addr + 16'(i)));
            q_data.push_back(d);
         end
      end
      s = 8'h00;
      for (int i = 1; i < fr.size(); i++) s = s + fr[i];
      if (bad_sum) s = s + 8'h01;
      fr.push_back(s);
      for (int i = 0; i < fr.size(); i++) begin
         if (i == fr.size() - 1)  send_byte(fr[i], 0);
         else if (i == pause_at)  send_byte(fr[i], pause);
         else                     send_byte(fr[i], 1);
      end
      chk(req, "status after checksum", status, exp_st);
      chk(req, "msg_ok pulse", msg_ok, good);
      chk(req, "msg_err pulse", msg_err, !good);
      if (inject) begin
         send_byte(SC, 0);
         send_byte(KREG, 0);
         send_byte(8'h00, 0);
      end
      repeat (len + 4) @(negedge clk);
      chk(req, "msg_ok back low", msg_ok, 0);
      chk(req, "pending expected writes", q_addr.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      in_valid   = 1'b0;
      in_byte    = 8'h00;
      idle_limit = 16'd20;
      rst_n      = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "status after reset", status, 3'b000);
      chk("R1", "strobes after reset", {reg_we, mem_we}, 2'b00);
      chk("R1", "pulses after reset", {msg_ok, msg_err}, 2'b00);

      // R9 noise before a frame is ignored
      send_byte(8'h13, 1);
      send_byte(8'h00, 1);
      send_byte(8'h5A, 1);
      send_frame(KREG, 16'h0040, 4, 8'h11, 1'b0, -1, 0, 1'b0, "R9");

      // R2 R4 register frame carrying 0xA5 as payload
      send_frame(KREG, 16'h0100, 5, 8'h3C, 1'b0, -1, 0, 1'b0, "R4");

      // R5 memory frame
      send_frame(KMEM, 16'h1200, 6, 8'h30, 1'b0, -1, 0, 1'b0, "R5");

      // R6 checksum mismatch
      send_frame(KREG, 16'h0050, 3, 8'h77, 1'b1, -1, 0, 1'b0, "R6");

      // R13 abandoned frame keeps status 010; R10 abort after timeout
      send_byte(SC, 1);
      send_byte(KREG, 1);
      send_byte(8'h00, 25);
      chk("R13", "status after abandoned frame", status, 3'b010);
      chk("R13", "pulses after abandoned frame", {msg_ok, msg_err}, 2'b00);
      send_frame(KMEM, 16'h0700, 3, 8'h05, 1'b0, -1, 0, 1'b0, "R10");

      // R10 pause ending on the idle_limit-th edge keeps the frame alive
      send_frame(KREG, 16'h0800, 4, 8'h44, 1'b0, 3, 18, 1'b0, "R10");

      // R7 unknown kind, then unknown kind with bad sum
      send_frame(8'h07, 16'h0060, 2, 8'h21, 1'b0, -1, 0, 1'b0, "R7");
      send_frame(8'h09, 16'h0061, 2, 8'h22, 1'b1, -1, 0, 1'b0, "R7");

      // R3 address wraps modulo 2^16
      send_frame(KMEM, 16'hFFFE, 4, 8'h90, 1'b0, -1, 0, 1'b0, "R3");

      // R8 length byte 0 means 256; R12 bytes during write-out ignored
      send_frame(KMEM, 16'h0300, 256, 8'h01, 1'b0, -1, 0, 1'b1, "R8");
      send_frame(KREG, 16'h0020, 2, 8'h66, 1'b0, -1, 0, 1'b0, "R12");

      // R11 idle_limit 0 disables the timeout
      idle_limit = 16'd0;
      send_frame(KREG, 16'h0010, 3, 8'hC0, 1'b0, 2, 200, 1'b0, "R11");

      chk("R3", "all expected writes seen", q_addr.size(), 0);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule